// File: doc/BRIEF.md
# Frame CRC Trailer Controller

This block sits at the tail of a byte-wide transmit path and decides what follows the final payload byte of each frame. Payload bytes pass from the input stream to the output stream in the same cycle. As they pass, the block folds each one into a running Ethernet CRC-32. Two per-frame flags travel with the input stream: `in_crc_add` asks for the checksum to be appended, and `in_crc_bad` asks for a deliberately corrupted checksum. The block reads both flags only on the beat marked as the end of the frame.

When that end beat is accepted, the block does one of three things. It closes the frame on that byte, or it appends the four correct checksum bytes, or it appends their bitwise complement. The corrupted trailer takes priority over the append flag.

Both streams follow valid/ready rules. A beat transfers on a rising edge where valid and ready are both high. While payload flows, `in_ready` mirrors `out_ready`, so back-pressure passes straight through. While trailer bytes are being sent, `in_ready` is held low. A pending trailer byte stays on the output, unchanged, until `out_ready` takes it.

Top module: `crc_trailer_tx`

## Requirements
- R1: While reset is asserted and after it is released with no traffic, `out_valid` is low and `in_ready` equals `out_ready`.
- R2: In the payload phase, `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready`, all in the same cycle.
- R3: When the end beat carries `in_crc_add`=0 and `in_crc_bad`=0, `out_last` is high on that payload byte and no trailer follows.
- R4: When the end beat carries `in_crc_add`=1 and `in_crc_bad`=0, four trailer bytes follow, least significant byte first. They hold the reflected CRC-32: polynomial 0x04C11DB7 (0xEDB88320 reflected), initial value 0xFFFFFFFF, final complement. For the payload ASCII "123456789" the trailer is 26 39 F4 CB.
- R5: When the end beat carries `in_crc_bad`=1, the trailer is the bitwise complement of the R4 trailer, whatever the value of `in_crc_add`. For "123456789" it is D9 C6 0B 34.
- R6: The values of `in_crc_add` and `in_crc_bad` on beats that are not end beats have no effect on the output.
- R7: The checksum restarts from its initial value at every frame, so two identical frames produce identical trailers.
- R8: While a trailer is pending, `in_ready` is low and `out_valid` is high. `out_last` is high only on the fourth trailer byte, and it is low on the end payload byte of a frame that gets a trailer.
- R9: A trailer byte that is offered while `out_ready` is low stays unchanged on `out_data` and `out_last` until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Beat is the end of the frame |
| in_crc_add | input | 1 | Append checksum (read on end beat only) |
| in_crc_bad | input | 1 | Append inverted checksum (read on end beat only) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | 8 | Payload or trailer byte |
| out_last | output | 1 | Beat is the end of the transmitted frame |

## Verification
Payload results are due in the same cycle as their input beat, because the path from input to output has no register. The first trailer byte is due in the cycle after the end beat is accepted, and each later trailer byte follows the cycle after its predecessor is accepted. The bench drives inputs just after each rising edge and compares every output at the falling edge against a behavioural model. The model advances its state only when it sees a transfer, so every expectation falls in the cycle the requirements name, even under irregular back-pressure. Separate checks collect each frame's output bytes and compare the trailer with the known values for the standard check string.

// File: rtl/crc_trailer_pkg.sv
package crc_trailer_pkg;
  localparam int BYTE_W       = 8;
  localparam int CRC_W        = 32;
  localparam int TRL_BYTES    = CRC_W / BYTE_W;
  localparam int TRL_CNT_W    = $clog2(TRL_BYTES);
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT     = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    TRL_NONE = 2'd0,
    TRL_GOOD = 2'd1,
    TRL_BAD  = 2'd2
  } trl_mode_e;

  typedef enum logic {
    ST_PASS  = 1'b0,
    ST_TRAIL = 1'b1
  } tx_state_e;

  // One byte of the reflected CRC-32, LSB of the byte first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      r = (r >> 1) ^ (CRC_POLY_REV & {CRC_W{r[0] ^ d[i]}});
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_trailer_mode.sv
module crc_trailer_mode
  import crc_trailer_pkg::*;
(
  input  logic      crc_add,
  input  logic      crc_bad,
  output trl_mode_e mode
);
  // The corrupted trailer takes priority over the append flag.
  always_comb begin
    if (crc_bad)      mode = TRL_BAD;
    else if (crc_add) mode = TRL_GOOD;
    else              mode = TRL_NONE;
  end
endmodule

// File: rtl/crc_trailer_crc.sv
module crc_trailer_crc
  import crc_trailer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_next
);
  logic [CRC_W-1:0] crc_q;

  assign crc_next = crc_step(crc_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= CRC_INIT;
    else if (step)  crc_q <= restart ? CRC_INIT : crc_next;
  end
endmodule

// File: rtl/crc_trailer_seq.sv
module crc_trailer_seq
  import crc_trailer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  trl_mode_e         mode,
  input  logic [CRC_W-1:0]  crc_next,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              trailing,
  output logic [BYTE_W-1:0] trl_byte,
  output logic              trl_last
);
  localparam logic [TRL_CNT_W-1:0] LAST_IDX = TRL_CNT_W'(TRL_BYTES - 1);

  tx_state_e              state_q;
  logic [CRC_W-1:0]       shift_q;
  logic [TRL_CNT_W-1:0]   idx_q;
  logic                   end_fire;

  assign trailing = (state_q == ST_TRAIL);
  assign in_ready = !trailing && out_ready;
  assign end_fire = in_valid && in_ready && in_last;
  assign trl_byte = shift_q[BYTE_W-1:0];
  assign trl_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PASS;
      shift_q <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_PASS: begin
          if (end_fire && mode != TRL_NONE) begin
            // crc_next still holds the register form; the correct
            // trailer is its complement, the bad trailer is it unchanged.
            shift_q <= (mode == TRL_BAD) ? crc_next : ~crc_next;
            idx_q   <= '0;
            state_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (out_ready) begin
            shift_q <= shift_q >> BYTE_W;
            idx_q   <= idx_q + 1'b1;
            if (trl_last) state_q <= ST_PASS;
          end
        end
        default: state_q <= ST_PASS;
      endcase
    end
  end
endmodule

// File: rtl/crc_trailer_tx.sv
module crc_trailer_tx
  import crc_trailer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_crc_add,
  input  logic              in_crc_bad,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  trl_mode_e         mode;
  logic [CRC_W-1:0]  crc_next;
  logic              trailing;
  logic [BYTE_W-1:0] trl_byte;
  logic              trl_last;
  logic              in_fire;

  assign in_fire = in_valid && in_ready;

  crc_trailer_mode u_mode (
    .crc_add (in_crc_add),
    .crc_bad (in_crc_bad),
    .mode    (mode)
  );

  crc_trailer_crc u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (in_fire),
    .restart  (in_last),
    .din      (in_data),
    .crc_next (crc_next)
  );

  crc_trailer_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .mode      (mode),
    .crc_next  (crc_next),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .trailing  (trailing),
    .trl_byte  (trl_byte),
    .trl_last  (trl_last)
  );

  always_comb begin
    if (trailing) begin
      out_valid = 1'b1;
      out_data  = trl_byte;
      out_last  = trl_last;
    end else begin
      out_valid = in_valid;
      out_data  = in_data;
      out_last  = in_last && (mode == TRL_NONE);
    end
  end
endmodule

// File: rtl/crc_trailer_tx_chk.sv
module crc_trailer_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_last,
  input logic       in_crc_add,
  input logic       in_crc_bad,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  // Counts trailer beats still owed, observed at the ports only.
  logic [2:0] owed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else if (in_valid && in_ready && in_last && (in_crc_add || in_crc_bad))
      owed_q <= 3'd4;
    else if (owed_q != 0 && out_valid && out_ready)
      owed_q <= owed_q - 1'b1;
  end

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == 0) |-> (in_ready == out_ready && out_valid == in_valid)) else $error("idle"); // R2

  AST_PLAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !in_crc_add && !in_crc_bad) |-> out_last) else $error("plain end"); // R3

  AST_TRAIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q != 0) |-> (!in_ready && out_valid)) else $error("trail block"); // R8

  AST_LAST_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q != 0 && out_last) |-> (owed_q == 3'd1)) else $error("last pos"); // R8

  AST_MID_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == 0 && in_valid && !in_last) |-> !out_last) else $error("mid last"); // R6

  AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q != 0 && !out_ready) |=> ($stable(out_data) && $stable(out_last) && out_valid)) else $error("hold"); // R9
endmodule

bind crc_trailer_tx crc_trailer_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_last    (in_last),
  .in_crc_add (in_crc_add),
  .in_crc_bad (in_crc_bad),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last)
);

// File: tb/crc_trailer_tx_bench.sv
`timescale 1ns/1ps
module crc_trailer_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_crc_add = 1'b0;
  logic       in_crc_bad = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0]  trl_q[$];
  logic [7:0]  obs_q[$];
  logic [31:0] model_crc = 32'hFFFFFFFF;

  always #10 clk = ~clk;   // 50 MHz

  crc_trailer_tx u_crc_trailer_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_crc_add(in_crc_add), .in_crc_bad(in_crc_bad),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Back-pressure source
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_mode ? lfsr[3] : 1'b1;
  end

  // Reference model, compared on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (trl_q.size() > 0) begin
        chk(!in_ready, "R8 in_ready", {31'd0, in_ready}, 32'd0);
        chk(out_valid, "R8 out_valid", {31'd0, out_valid}, 32'd1);
        chk(out_data == trl_q[0], "R4/R5/R9 trailer byte", {24'd0, out_data}, {24'd0, trl_q[0]});
        chk(out_last == (trl_q.size() == 1), "R8 trailer last", {31'd0, out_last},
            {31'd0, trl_q.size() == 1});
        if (out_ready) begin
          obs_q.push_back(out_data);
          void'(trl_q.pop_front());
        end
      end else begin
        chk(in_ready == out_ready, "R2 in_ready", {31'd0, in_ready}, {31'd0, out_ready});
        chk(out_valid == in_valid, "R2 out_valid", {31'd0, out_valid}, {31'd0, in_valid});
        if (in_valid) begin
          chk(out_data == in_data, "R2 out_data", {24'd0, out_data}, {24'd0, in_data});
          chk(out_last == (in_last && !in_crc_add && !in_crc_bad), "R3/R6/R8 payload last",
              {31'd0, out_last}, {31'd0, in_last && !in_crc_add && !in_crc_bad});
        end
        if (in_valid && out_ready) begin
          logic [31:0] t;
          obs_q.push_back(out_data);
          model_crc = ref_crc(model_crc, in_data);
          if (in_last) begin
            t = in_crc_bad ? model_crc : ~model_crc;
            if (in_crc_add || in_crc_bad)
              for (int k = 0; k < 4; k++) trl_q.push_back(t[8*k +: 8]);
            model_crc = 32'hFFFFFFFF;   // R7
          end
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit last, input bit add, input bit bad);
    bit ok;
    in_valid = 1'b1; in_data = d; in_last = last; in_crc_add = add; in_crc_bad = bad;
    forever begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #2;
      if (ok) break;
    end
    in_valid = 1'b0; in_last = 1'b0; in_crc_add = 1'b0; in_crc_bad = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] f[$], input bit add, input bit bad, input bit noisy);
    obs_q.delete();
    foreach (f[i]) begin
      if (i == f.size() - 1) send_byte(f[i], 1'b1, add, bad);
      else if (noisy)        send_byte(f[i], 1'b0, 1'b1, i[0]);   // R6
      else                   send_byte(f[i], 1'b0, 1'b0, 1'b0);
    end
    while (trl_q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic chk_tail(input int n, input logic [31:0] exp, input string req);
    logic [31:0] got;
    got = {obs_q[n+3], obs_q[n+2], obs_q[n+1], obs_q[n]};
    chk(obs_q.size() == n + 4, {req, " length"}, obs_q.size(), n + 4);
    chk(got == exp, req, got, exp);
  endtask

  initial begin
    logic [7:0] f9[$];
    logic [7:0] fr[$];
    f9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    #5;
    // R1: during reset
    @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == out_ready, "R1 in_ready in reset", {31'd0, in_ready}, {31'd0, out_ready});
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    @(posedge clk); #2;

    // R4: check string, correct trailer 26 39 F4 CB (read as word CBF43926)
    send_frame(f9, 1'b1, 1'b0, 1'b0);
    chk_tail(9, 32'hCBF43926, "R4 good trailer");
    // R7: same frame again yields the same trailer
    send_frame(f9, 1'b1, 1'b0, 1'b0);
    chk_tail(9, 32'hCBF43926, "R7 repeat trailer");
    // R5: bad trailer with and without append flag
    send_frame(f9, 1'b0, 1'b1, 1'b0);
    chk_tail(9, 32'h340BC6D9, "R5 bad trailer add=0");
    send_frame(f9, 1'b1, 1'b1, 1'b0);
    chk_tail(9, 32'h340BC6D9, "R5 bad trailer add=1");
    // R3: no trailer
    send_frame(f9, 1'b0, 1'b0, 1'b0);
    chk(obs_q.size() == 9, "R3 no trailer length", obs_q.size(), 9);
    // R6: flags on earlier beats ignored
    send_frame(f9, 1'b1, 1'b0, 1'b1);
    chk_tail(9, 32'hCBF43926, "R6 noisy flags");
    send_frame(f9, 1'b0, 1'b0, 1'b1);
    chk(obs_q.size() == 9, "R6 noisy flags no trailer", obs_q.size(), 9);

    // R9 and mixed traffic under back-pressure
    bp_mode = 1'b1;
    send_frame(f9, 1'b1, 1'b0, 1'b0);
    chk_tail(9, 32'hCBF43926, "R9 trailer under back-pressure");
    for (int n = 0; n < 40; n++) begin
      fr.delete();
      for (int j = 0; j <= (n % 7); j++) fr.push_back(8'(n * 29 + j * 13));
      send_frame(fr, n[0], n[1] & n[2], n[2]);
    end
    fr = '{8'hA5};
    send_frame(fr, 1'b1, 1'b0, 1'b0);   // single-byte frame
    bp_mode = 1'b0;
    repeat (4) @(posedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule